// File: doc/BRIEF.md
# SSIF Response Block Segmenter

This block holds one management-controller response of up to 255 bytes and hands it to a host as a sequence of SMBus block reads, each at most 32 data bytes long. The controller side loads a response through a write port: a start pulse that carries the total length, followed by one byte per write strobe. The host side first selects a block with a command code and an optional block number. It then pulls the staged block one byte per request strobe. The first byte returned is always a length byte, and the block's bytes follow it.

A response that fits in one block goes out unchanged behind its length byte. A longer response is split into parts. The first part carries a two-byte start header and 30 data bytes. Each later part carries one number byte and up to 31 data bytes. The number byte counts middle parts from zero, and the last part carries 0xFF in its place. The host can walk the parts in order or ask again for any part by its number. A selection that names no valid part raises an error flag. The byte stream then reads as 0xFF until a valid part is selected.

Top module: `ssif_rsp_segmenter`

## Requirements
- R1: After reset, rd_data is 0xFF and sel_err is 0. rd_data changes only in the clock cycle after a rd_strobe.
- R2: For a response of length L with 1 ≤ L ≤ 32, selecting block 0 stages L as the length byte, followed by the L response bytes in order.
- R3: For a response of 32 bytes or fewer, selecting any block number other than 0 fails.
- R4: For a response longer than 32 bytes, block 0 reads as 32, 0x00, 0x01, then response bytes 0 to 29.
- R5: For a response longer than 32 bytes, block n (n ≥ 1) starts at response offset 30 + (n−1)×31. When more than 31 bytes remain from that offset, the block reads as 32, then n−1, then 31 data bytes.
- R6: When 31 or fewer bytes remain from the start offset of block n, the block reads as (remaining+1), then 0xFF, then the remaining bytes.
- R7: Selecting a block whose start offset is at or past the response length fails.
- R8: Any selection fails when no response is held, either after reset or after a load of length 0.
- R9: A load length above 255 keeps only the first 255 bytes, and byte 2 of the stored response becomes 0xC6.
- R10: A byte request past the 33-byte staging window, or past the last byte of the selected block, returns 0xFF.
- R11: A load start sets the block counter to 0, rewinds the byte pointer and clears both the selection and sel_err. Byte requests return 0xFF until a block is selected, and a following next-block command selects block 1.
- R12: Every read-command selection rewinds the byte pointer, so the next byte request returns the length byte.
- R13: A failed selection sets sel_err, and byte requests then return 0xFF. A later valid selection clears sel_err.
- R14: Code 0x03 selects block 0 and code 0x09 selects the stored block number plus one. Code 0x0A selects the block given on cmd_arg, and fails if cmd_arg_valid is low. Any other code changes neither the selection, the pointer nor sel_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_begin | input | 1 | Starts a new response load and latches ld_len |
| ld_len | input | LEN_W | Total response length for the load |
| ld_wr | input | 1 | Writes ld_wdata at the next response position |
| ld_wdata | input | 8 | Response byte to store |
| cmd_valid | input | 1 | Host command strobe |
| cmd_code | input | 8 | Host command code (0x03, 0x09, 0x0A) |
| cmd_arg | input | 8 | Block number used by code 0x0A |
| cmd_arg_valid | input | 1 | cmd_arg is present |
| rd_strobe | input | 1 | Requests the next staged byte |
| rd_data | output | 8 | Last byte returned |
| sel_err | output | 1 | The last selection failed |

## Verification
The bench probes the boundaries between the one-block and multi-part formats, at lengths 32 and 33. A design with an off-by-one there would either split a 32-byte response or send 33 bytes as a single oversized block. It walks a 100-byte response forward and then backward by retry. This exposes a wrong start-offset formula, numbering of middle parts from one, or a missing end marker, which would show up as shifted data or a wrong header byte. It also loads a 300-byte response and checks that the stored length is clipped, that the completion-code byte is replaced, and that the part beyond the clipped length is refused. Finally it checks the error and pointer paths: a design that kept serving stale bytes after a failed selection, or that resumed mid-block after a reselect, would return data where 0xFF or the length byte belongs.

// File: rtl/ssif_seg_pkg.sv
package ssif_seg_pkg;
    localparam int BLK_BYTES   = 32;
    localparam int STAGE_BYTES = BLK_BYTES + 1;
    localparam int FIRST_DATA  = BLK_BYTES - 2;
    localparam int MID_DATA    = BLK_BYTES - 1;
    localparam int POS_W       = $clog2(STAGE_BYTES + 1);

    localparam logic [7:0] CMD_FIRST = 8'h03;
    localparam logic [7:0] CMD_NEXT  = 8'h09;
    localparam logic [7:0] CMD_RETRY = 8'h0A;
    localparam logic [7:0] END_MARK  = 8'hFF;
    localparam logic [7:0] IDLE_BYTE = 8'hFF;

    // Description of one staged block, derived from response length and number
    typedef struct packed {
        logic             ok;
        logic [7:0]       len_byte;
        logic [1:0]       hdr_n;
        logic [7:0]       hdr0;
        logic [7:0]       hdr1;
        logic [15:0]      start;
        logic [POS_W-1:0] cnt;
    } blk_desc_t;
endpackage

// File: rtl/ssif_rsp_store.sv
module ssif_rsp_store
    import ssif_seg_pkg::*;
#(
    parameter int         MAX_LEN   = 255,
    parameter int         LEN_W     = 9,
    parameter logic [7:0] TRUNC_CC  = 8'hC6,
    parameter int         CC_INDEX  = 2,
    localparam int        AW        = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_begin,
    input  logic [LEN_W-1:0] ld_len,
    input  logic             ld_wr,
    input  logic [7:0]       ld_wdata,
    input  logic [15:0]      rd_addr,
    output logic [7:0]       rd_byte,
    output logic [AW-1:0]    rsp_len
);
    typedef struct packed {
        logic [AW-1:0] len;
        logic [AW-1:0] idx;
        logic          trunc;
    } store_st_t;

    store_st_t  st_d, st_q;
    logic [7:0] mem [MAX_LEN];
    logic       over;
    logic       wr_en;
    logic [7:0] wr_byte;

    always_comb begin
        st_d    = st_q;
        over    = ld_len > LEN_W'(MAX_LEN);
        wr_en   = !ld_begin && ld_wr && (st_q.idx < AW'(MAX_LEN));
        wr_byte = (st_q.trunc && st_q.idx == AW'(CC_INDEX)) ? TRUNC_CC : ld_wdata;
        if (ld_begin) begin
            st_d.len   = over ? AW'(MAX_LEN) : ld_len[AW-1:0];
            st_d.idx   = '0;
            st_d.trunc = over;
        end else if (wr_en) begin
            st_d.idx = st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[st_q.idx] <= wr_byte;
        end
    end

    always_comb begin
        if (rd_addr < 16'(MAX_LEN)) begin
            rd_byte = mem[rd_addr[AW-1:0]];
        end else begin
            rd_byte = IDLE_BYTE;
        end
    end

    assign rsp_len = st_q.len;
endmodule

// File: rtl/ssif_blk_select.sv
module ssif_blk_select
    import ssif_seg_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic [AW-1:0] rsp_len,
    input  logic [7:0]    blk,
    output blk_desc_t     desc
);
    logic [15:0]      len16;
    logic [15:0]      start16;
    logic [15:0]      rem16;
    logic [POS_W-1:0] cnt;

    always_comb begin
        len16   = 16'(rsp_len);
        start16 = 16'(FIRST_DATA) + (16'(blk) - 16'd1) * 16'(MID_DATA);
        rem16   = len16 - start16;
        cnt     = '0;
        desc    = '0;
        if (len16 == 16'd0) begin
            desc.ok = 1'b0;
        end else if (len16 <= 16'(BLK_BYTES)) begin
            // whole response fits in a single block
            desc.ok       = (blk == 8'd0);
            desc.len_byte = 8'(len16);
            desc.hdr_n    = 2'd0;
            desc.cnt      = POS_W'(len16);
        end else if (blk == 8'd0) begin
            desc.ok       = 1'b1;
            desc.len_byte = 8'(BLK_BYTES);
            desc.hdr_n    = 2'd2;
            desc.hdr0     = 8'h00;
            desc.hdr1     = 8'h01;
            desc.cnt      = POS_W'(FIRST_DATA);
        end else if (start16 >= len16) begin
            desc.ok = 1'b0;
        end else begin
            desc.ok    = 1'b1;
            desc.start = start16;
            desc.hdr_n = 2'd1;
            if (rem16 > 16'(MID_DATA)) begin
                cnt       = POS_W'(MID_DATA);
                desc.hdr0 = blk - 8'd1;
            end else begin
                cnt       = POS_W'(rem16);
                desc.hdr0 = END_MARK;
            end
            desc.cnt      = cnt;
            desc.len_byte = 8'(cnt) + 8'd1;
        end
    end
endmodule

// File: rtl/ssif_byte_pick.sv
module ssif_byte_pick
    import ssif_seg_pkg::*;
(
    input  blk_desc_t        desc,
    input  logic [POS_W-1:0] pos,
    input  logic [7:0]       mem_byte,
    output logic [15:0]      mem_addr,
    output logic [7:0]       pick
);
    logic [POS_W-1:0] first;
    logic [POS_W-1:0] off;

    always_comb begin
        first    = POS_W'(desc.hdr_n) + POS_W'(1);
        off      = pos - first;
        mem_addr = desc.start + 16'(off);
        pick     = IDLE_BYTE;
        if (!desc.ok || pos >= POS_W'(STAGE_BYTES)) begin
            pick = IDLE_BYTE;
        end else if (pos == '0) begin
            pick = desc.len_byte;
        end else if (pos < first) begin
            pick = (pos == POS_W'(1)) ? desc.hdr0 : desc.hdr1;
        end else if (off < desc.cnt) begin
            pick = mem_byte;
        end
    end
endmodule

// File: rtl/ssif_rsp_segmenter.sv
module ssif_rsp_segmenter
    import ssif_seg_pkg::*;
#(
    parameter int         MAX_LEN  = 255,
    parameter int         LEN_W    = 9,
    parameter logic [7:0] TRUNC_CC = 8'hC6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_begin,
    input  logic [LEN_W-1:0] ld_len,
    input  logic             ld_wr,
    input  logic [7:0]       ld_wdata,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_code,
    input  logic [7:0]       cmd_arg,
    input  logic             cmd_arg_valid,
    input  logic             rd_strobe,
    output logic [7:0]       rd_data,
    output logic             sel_err
);
    localparam int AW     = $clog2(MAX_LEN + 1);
    localparam int N_SEL  = 2;   // 0: candidate selection, 1: current selection
    localparam int CAND   = 0;
    localparam int CURR   = 1;

    typedef struct packed {
        logic [7:0]       blk;
        logic [POS_W-1:0] pos;
        logic             err;
        logic             sel;
        logic [7:0]       rdat;
    } seg_st_t;

    seg_st_t     st_d, st_q;
    logic [AW-1:0] rsp_len;
    logic [15:0] mem_addr;
    logic [7:0]  mem_byte;
    logic [7:0]  pick;
    logic [7:0]  cand_blk;
    logic        is_rd_cmd;
    logic        no_arg;
    logic [7:0]  blk_in [N_SEL];
    blk_desc_t   desc   [N_SEL];

    ssif_rsp_store #(
        .MAX_LEN  (MAX_LEN),
        .LEN_W    (LEN_W),
        .TRUNC_CC (TRUNC_CC)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_begin (ld_begin),
        .ld_len   (ld_len),
        .ld_wr    (ld_wr),
        .ld_wdata (ld_wdata),
        .rd_addr  (mem_addr),
        .rd_byte  (mem_byte),
        .rsp_len  (rsp_len)
    );

    assign blk_in[CAND] = cand_blk;
    assign blk_in[CURR] = st_q.blk;

    for (genvar g = 0; g < N_SEL; g++) begin : g_sel
        ssif_blk_select #(.AW(AW)) u_sel (
            .rsp_len (rsp_len),
            .blk     (blk_in[g]),
            .desc    (desc[g])
        );
    end

    ssif_byte_pick u_pick (
        .desc     (desc[CURR]),
        .pos      (st_q.pos),
        .mem_byte (mem_byte),
        .mem_addr (mem_addr),
        .pick     (pick)
    );

    always_comb begin
        is_rd_cmd = 1'b1;
        no_arg    = 1'b0;
        unique case (cmd_code)
            CMD_FIRST: cand_blk = 8'd0;
            CMD_NEXT:  cand_blk = st_q.blk + 8'd1;
            CMD_RETRY: begin
                cand_blk = cmd_arg;
                no_arg   = !cmd_arg_valid;
            end
            default: begin
                cand_blk  = st_q.blk;
                is_rd_cmd = 1'b0;
            end
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (ld_begin) begin
            st_d.blk = 8'd0;
            st_d.pos = '0;
            st_d.err = 1'b0;
            st_d.sel = 1'b0;
        end else if (cmd_valid && is_rd_cmd) begin
            st_d.pos = '0;
            if (no_arg) begin
                st_d.err = 1'b1;
                st_d.sel = 1'b0;
            end else begin
                st_d.blk = cand_blk;
                st_d.err = !desc[CAND].ok;
                st_d.sel = desc[CAND].ok;
            end
        end else if (rd_strobe) begin
            st_d.rdat = (st_q.sel && !st_q.err) ? pick : IDLE_BYTE;
            if (st_q.pos != POS_W'(STAGE_BYTES)) begin
                st_d.pos = st_q.pos + POS_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.blk  <= 8'd0;
            st_q.pos  <= '0;
            st_q.err  <= 1'b0;
            st_q.sel  <= 1'b0;
            st_q.rdat <= IDLE_BYTE;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.rdat;
    assign sel_err = st_q.err;
endmodule

// File: rtl/ssif_seg_checker.sv
module ssif_seg_checker
    import ssif_seg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             ld_begin,
    input logic             cmd_valid,
    input logic [7:0]       cmd_code,
    input logic             rd_strobe,
    input logic [7:0]       rd_data,
    input logic             sel_err,
    input logic [POS_W-1:0] byte_pos,
    input logic [7:0]       blk_num
);
    logic rd_cmd;
    logic quiet_rd;
    assign rd_cmd   = cmd_valid && (cmd_code == CMD_FIRST || cmd_code == CMD_NEXT ||
                                    cmd_code == CMD_RETRY);
    assign quiet_rd = rd_strobe && !cmd_valid && !ld_begin;

    // R1: the returned byte only moves after a byte request
    a_r1_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> $stable(rd_data));

    // R10: pointer never leaves the staging window
    a_r10_pos_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        byte_pos <= POS_W'(STAGE_BYTES));

    // R10: requests at the window end return the idle byte
    a_r10_ff_past_end: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_rd && byte_pos == POS_W'(STAGE_BYTES)) |=> rd_data == IDLE_BYTE);

    // R13: error flag forces the idle byte
    a_r13_err_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_rd && sel_err) |=> rd_data == IDLE_BYTE);

    // R12: every read command rewinds the pointer
    a_r12_select_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cmd && !ld_begin) |=> byte_pos == '0);

    // R11: a load start clears counter, pointer and error
    a_r11_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ld_begin |=> (byte_pos == '0 && blk_num == 8'd0 && !sel_err));
endmodule

bind ssif_rsp_segmenter ssif_seg_checker u_seg_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_begin  (ld_begin),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .rd_strobe (rd_strobe),
    .rd_data   (rd_data),
    .sel_err   (sel_err),
    .byte_pos  (st_q.pos),
    .blk_num   (st_q.blk)
);

// File: tb/ssif_rsp_segmenter_test.sv
module ssif_rsp_segmenter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ld_begin = 1'b0;
    logic [8:0] ld_len = '0;
    logic       ld_wr = 1'b0;
    logic [7:0] ld_wdata = '0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_code = '0;
    logic [7:0] cmd_arg = '0;
    logic       cmd_arg_valid = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] rd_data;
    logic       sel_err;

    always #2 clk = ~clk;

    ssif_rsp_segmenter uut (
        .clk(clk), .rst_n(rst_n), .ld_begin(ld_begin), .ld_len(ld_len),
        .ld_wr(ld_wr), .ld_wdata(ld_wdata), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .cmd_arg(cmd_arg), .cmd_arg_valid(cmd_arg_valid),
        .rd_strobe(rd_strobe), .rd_data(rd_data), .sel_err(sel_err)
    );

    int checks = 0;
    int fails  = 0;
    int m_len  = 0;
    int m_seed = 0;
    bit m_trunc = 1'b0;

    typedef struct packed {
        logic [7:0] code;
        logic [7:0] arg;
        logic       av;
        logic       exp_err;
        logic [7:0] mblk;
        logic [3:0] tag;
    } vec_t;

    // 100-byte response: parts 0..3 valid, part 3 is final with 8 bytes
    localparam vec_t VECS [9] = '{
        '{8'h03, 8'd0, 1'b0, 1'b0, 8'd0, 4'd4},   // R4 first part
        '{8'h09, 8'd0, 1'b0, 1'b0, 8'd1, 4'd5},   // R5 middle 0
        '{8'h09, 8'd0, 1'b0, 1'b0, 8'd2, 4'd5},   // R5 middle 1
        '{8'h09, 8'd0, 1'b0, 1'b0, 8'd3, 4'd6},   // R6 final part
        '{8'h09, 8'd0, 1'b0, 1'b1, 8'd0, 4'd7},   // R7 past the end
        '{8'h0A, 8'd2, 1'b1, 1'b0, 8'd2, 4'd14},  // R14 retry earlier part
        '{8'h0A, 8'd0, 1'b1, 1'b0, 8'd0, 4'd14},  // R14 retry first part
        '{8'h0A, 8'd4, 1'b1, 1'b1, 8'd0, 4'd7},   // R7 retry past the end
        '{8'h0A, 8'd0, 1'b0, 1'b1, 8'd0, 4'd14}   // R14 retry without number
    };

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            default: return "R14";
        endcase
    endfunction

    function automatic logic [7:0] dbyte(input int i);
        if (m_trunc && i == 2) return 8'hC6;
        return 8'(i * 13 + m_seed);
    endfunction

    function automatic logic [7:0] model(input int blk, input int p);
        int start, rem, cnt;
        if (p >= 33) return 8'hFF;
        if (m_len <= 32) begin
            if (p == 0) return 8'(m_len);
            if (p - 1 < m_len) return dbyte(p - 1);
            return 8'hFF;
        end
        if (blk == 0) begin
            if (p == 0) return 8'd32;
            if (p == 1) return 8'h00;
            if (p == 2) return 8'h01;
            return dbyte(p - 3);
        end
        start = 30 + (blk - 1) * 31;
        rem   = m_len - start;
        cnt   = (rem > 31) ? 31 : rem;
        if (p == 0) return 8'(cnt + 1);
        if (p == 1) return (rem > 31) ? 8'(blk - 1) : 8'hFF;
        if (p - 2 < cnt) return dbyte(start + p - 2);
        return 8'hFF;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic load(input int n, input int seed);
        ld_begin = 1'b1;
        ld_len   = 9'(n);
        @(negedge clk);
        ld_begin = 1'b0;
        for (int i = 0; i < n; i++) begin
            ld_wr    = 1'b1;
            ld_wdata = 8'(i * 13 + seed);
            @(negedge clk);
        end
        ld_wr   = 1'b0;
        m_len   = (n > 255) ? 255 : n;
        m_trunc = (n > 255);
        m_seed  = seed;
    endtask

    task automatic sel(input logic [7:0] code, input logic [7:0] arg, input logic av);
        cmd_valid     = 1'b1;
        cmd_code      = code;
        cmd_arg       = arg;
        cmd_arg_valid = av;
        @(negedge clk);
        cmd_valid     = 1'b0;
        cmd_arg_valid = 1'b0;
    endtask

    task automatic rd(output logic [7:0] b);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        b = rd_data;
    endtask

    task automatic read_block(input string tag, input int blk);
        logic [7:0] b;
        for (int p = 0; p < 35; p++) begin
            rd(b);
            chk(tag, b, model(blk, p));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", rd_data, 8'hFF);
        chk("R1", 8'(sel_err), 8'd0);

        // R8: nothing loaded yet
        sel(8'h03, 8'd0, 1'b0);
        chk("R8", 8'(sel_err), 8'd1);
        rd(b); chk("R8", b, 8'hFF);

        // R2: short response, plus R10 tail
        load(20, 1);
        sel(8'h03, 8'd0, 1'b0);
        chk("R2", 8'(sel_err), 8'd0);
        read_block("R2", 0);

        // R3 and R13
        sel(8'h0A, 8'd1, 1'b1);
        chk("R3", 8'(sel_err), 8'd1);
        rd(b); chk("R13", b, 8'hFF);
        sel(8'h03, 8'd0, 1'b0);
        chk("R13", 8'(sel_err), 8'd0);
        rd(b); chk("R13", b, 8'd20);

        // R12: reselect mid-block
        rd(b); rd(b);
        sel(8'h03, 8'd0, 1'b0);
        rd(b); chk("R12", b, 8'd20);

        // R14: unknown code is ignored
        rd(b); chk("R14", b, dbyte(0));
        sel(8'h05, 8'd0, 1'b1);
        chk("R14", 8'(sel_err), 8'd0);
        rd(b); chk("R14", b, dbyte(1));

        // R10: 32-byte single block fills the window exactly
        load(32, 7);
        sel(8'h03, 8'd0, 1'b0);
        read_block("R10", 0);

        // 33 bytes: smallest multi-part response
        load(33, 2);
        sel(8'h03, 8'd0, 1'b0);
        read_block("R4", 0);
        sel(8'h09, 8'd0, 1'b0);
        chk("R6", 8'(sel_err), 8'd0);
        read_block("R6", 1);

        // table walk over a 100-byte response
        load(100, 5);
        for (int v = 0; v < 9; v++) begin
            sel(VECS[v].code, VECS[v].arg, VECS[v].av);
            chk(tag_name(VECS[v].tag), 8'(sel_err), 8'(VECS[v].exp_err));
            if (VECS[v].exp_err) begin
                rd(b); chk("R13", b, 8'hFF);
            end else begin
                read_block(tag_name(VECS[v].tag), int'(VECS[v].mblk));
            end
        end

        // R11: new load resets counter and selection
        sel(8'h09, 8'd0, 1'b0);
        load(100, 9);
        chk("R11", 8'(sel_err), 8'd0);
        rd(b); chk("R11", b, 8'hFF);
        sel(8'h09, 8'd0, 1'b0);
        chk("R11", 8'(sel_err), 8'd0);
        read_block("R11", 1);

        // R9: oversized response
        load(300, 3);
        sel(8'h03, 8'd0, 1'b0);
        read_block("R9", 0);
        sel(8'h0A, 8'd8, 1'b1);
        chk("R9", 8'(sel_err), 8'd0);
        read_block("R9", 8);
        sel(8'h0A, 8'd9, 1'b1);
        chk("R9", 8'(sel_err), 8'd1);

        // R8: zero-length load
        load(0, 0);
        sel(8'h03, 8'd0, 1'b0);
        chk("R8", 8'(sel_err), 8'd1);
        rd(b); chk("R8", b, 8'hFF);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule